// File: doc/BRIEF.md
# Eight-Line Interrupt Controller Core

This block arbitrates eight interrupt request lines for a processor and hands it an 8-bit interrupt vector. Software reaches it through two byte-wide addresses selected by one address bit: a command address (bit clear) and a data address (bit set). A byte written to the command address with bit 4 set starts a setup sequence. The data writes that follow set the vector base, then optionally the cascade-occupied lines and the mode byte, and the controller works out which of these it still expects. Outside setup, the data address holds the line mask, and command writes either end interrupts or arm a one-shot read of the in-service set.

The request lines are single-cycle strobes. No request is ever held pending: a strobed line is either granted on the next clock edge or dropped. A granted line is marked in service unless auto end-of-interrupt is on. The vector equals the programmed base plus the line number and is shown for one cycle with a valid flag. Read data is combinational from the selected register.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset the mask, in-service and cascade registers are zero, auto end-of-interrupt is off, setup is inactive (the first data write loads the mask), and `vec_valid` is low.
- R2: A command write with bit 4 set latches the byte as the setup configuration and starts setup. The next data write sets the vector base to the byte ANDed with 0xF8.
- R3: After the base byte, setup expects further bytes as configuration bits 1 (single) and 0 (mode byte needed) select. If bit 1 is clear, the next data byte loads the cascade register. If bit 0 is set, one more byte is the mode byte. Setup ends after the last expected byte, and the next data write loads the mask.
- R4: In the mode byte, bit 1 sets auto end-of-interrupt, so a grant does not mark its line in service. Bit 0 has no effect. The setting holds until the next mode byte or reset.
- R5: Outside setup a data write loads the mask and a data read returns it. Data writes during setup leave the mask unchanged.
- R6: A command write of exactly 0x0B (bit 4 clear, bit 3 set) arms a flag: the next command read returns the in-service register and clears the flag. Other values with bit 4 clear and bit 3 set have no effect.
- R7: A command read with the flag clear returns 0x00.
- R8: A command write with bits 4 and 3 clear and bit 5 set ends interrupts. With bit 6 set it clears the in-service bit numbered by bits 2:0, and with bit 6 clear it clears all in-service bits. With bit 5 clear the write has no effect.
- R9: A strobe on line n is dropped when mask bit n, cascade bit n or in-service bit n is set.
- R10: An accepted strobe on line n gives `vec_valid` high for one cycle after the next clock edge, with `vec_out` = base + n, and sets in-service bit n unless auto end-of-interrupt is on.
- R11: When several strobes are accepted in one cycle, the lowest-numbered line is granted and the others are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register select: 0 command, 1 data |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe (consumes the armed in-service read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address |
| irq_req | input | 8 | Request strobes, one per line |
| vec_valid | output | 1 | Vector valid, one cycle per grant |
| vec_out | output | 8 | Granted interrupt vector |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together and that each write or read lasts a single cycle, so one register access is decoded per clock. They also assume that request strobes are one cycle wide and that the grant is consumed in the cycle `vec_valid` is shown. The bench drives every access and strobe as a one-cycle pulse on the falling edge. It never overlaps a read with a write, and it runs each setup sequence to its end before issuing operation commands, so the decoder always sees a well-formed byte stream.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NLINES = 8;
  localparam int LW     = $clog2(NLINES);
  localparam int DW     = 8;
  localparam logic [DW-1:0] ISR_READ_CMD = 8'h0B;
  localparam logic [DW-1:0] BASE_KEEP    = 8'hF8;

  typedef logic [DW-1:0]     byte_t;
  typedef logic [NLINES-1:0] lines_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_BASE, ST_CASC, ST_MODE
  } init_st_t;

  typedef struct packed {
    logic          setup_start;
    logic          arm_isr_rd;
    logic          end_one;
    logic          end_all;
    logic [LW-1:0] end_line;
  } cmd_t;

  function automatic byte_t base_of(byte_t v);
    return v & BASE_KEEP;
  endfunction

  function automatic byte_t vector_for(byte_t base, logic [LW-1:0] n);
    return base + byte_t'(n);
  endfunction

  function automatic lines_t pick_lowest(lines_t v);
    return v & (~v + lines_t'(1));
  endfunction

  function automatic logic [LW-1:0] line_index(lines_t onehot);
    logic [LW-1:0] idx;
    idx = '0;
    for (int i = 0; i < NLINES; i++)
      if (onehot[i]) idx = LW'(i);
    return idx;
  endfunction
endpackage

// File: rtl/irqc_cmd_dec.sv
module irqc_cmd_dec
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_wr,
  input  logic  cmd_rd,
  input  byte_t wdata,
  output cmd_t  cmd,
  output logic  isr_armed
);
  always_comb begin
    cmd = '0;
    cmd.end_line = wdata[LW-1:0];
    if (cmd_wr) begin
      if (wdata[4])
        cmd.setup_start = 1'b1;
      else if (wdata[3])
        cmd.arm_isr_rd = (wdata == ISR_READ_CMD);
      else if (wdata[5]) begin
        cmd.end_one = wdata[6];
        cmd.end_all = !wdata[6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      isr_armed <= 1'b0;
    else if (cmd.arm_isr_rd)
      isr_armed <= 1'b1;
    else if (cmd_rd)
      isr_armed <= 1'b0;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   setup_start,
  input  logic   data_wr,
  input  byte_t  wdata,
  output logic   init_active,
  output byte_t  offset_q,
  output lines_t casc_q,
  output lines_t mask_q,
  output logic   aeoi_q
);
  init_st_t st_q;
  byte_t    cfg_q;
  logic     single_mode, need_mode;

  assign single_mode = cfg_q[1];
  assign need_mode   = cfg_q[0];
  assign init_active = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cfg_q    <= '0;
      offset_q <= '0;
      casc_q   <= '0;
      mask_q   <= '0;
      aeoi_q   <= 1'b0;
    end else if (setup_start) begin
      st_q  <= ST_BASE;
      cfg_q <= wdata;
    end else if (data_wr) begin
      unique case (st_q)
        ST_IDLE: mask_q <= wdata;
        ST_BASE: begin
          offset_q <= base_of(wdata);
          if (!single_mode) st_q <= ST_CASC;
          else if (need_mode) st_q <= ST_MODE;
          else st_q <= ST_IDLE;
        end
        ST_CASC: begin
          casc_q <= wdata;
          st_q   <= need_mode ? ST_MODE : ST_IDLE;
        end
        ST_MODE: begin
          aeoi_q <= wdata[1];
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqc_service.sv
module irqc_service
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  lines_t        irq_req,
  input  lines_t        mask_q,
  input  lines_t        casc_q,
  input  logic          aeoi_q,
  input  byte_t         offset_q,
  input  logic          end_one,
  input  logic          end_all,
  input  logic [LW-1:0] end_line,
  output lines_t        isr_q,
  output lines_t        grant_vec,
  output logic          vec_valid,
  output byte_t         vec_out
);
  lines_t        eligible, isr_d;
  logic [LW-1:0] grant_line;
  logic          grant_any;

  assign eligible   = irq_req & ~mask_q & ~casc_q & ~isr_q;
  assign grant_vec  = pick_lowest(eligible);
  assign grant_any  = |grant_vec;
  assign grant_line = line_index(grant_vec);

  always_comb begin
    isr_d = isr_q;
    if (end_all) isr_d = '0;
    else if (end_one) isr_d[end_line] = 1'b0;
    if (grant_any && !aeoi_q) isr_d = isr_d | grant_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q     <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      isr_q     <= isr_d;
      vec_valid <= grant_any;
      if (grant_any) vec_out <= vector_for(offset_q, grant_line);
    end
  end
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_req,
  output logic       vec_valid,
  output logic [7:0] vec_out
);
  cmd_t   cmd;
  logic   isr_armed, init_active, aeoi_q;
  byte_t  offset_q;
  lines_t casc_q, mask_q, isr_q, grant_vec;
  logic   cmd_wr, cmd_rd, data_wr;

  assign cmd_wr  = wr_en && !addr;
  assign data_wr = wr_en && addr;
  assign cmd_rd  = rd_en && !addr;

  irqc_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .wdata(wdata), .cmd(cmd), .isr_armed(isr_armed)
  );

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .setup_start(cmd.setup_start),
    .data_wr(data_wr), .wdata(wdata), .init_active(init_active),
    .offset_q(offset_q), .casc_q(casc_q), .mask_q(mask_q), .aeoi_q(aeoi_q)
  );

  irqc_service u_svc (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_q(mask_q),
    .casc_q(casc_q), .aeoi_q(aeoi_q), .offset_q(offset_q),
    .end_one(cmd.end_one), .end_all(cmd.end_all), .end_line(cmd.end_line),
    .isr_q(isr_q), .grant_vec(grant_vec), .vec_valid(vec_valid),
    .vec_out(vec_out)
  );

  always_comb begin
    if (addr) rdata = mask_q;
    else if (isr_armed) rdata = isr_q;
    else rdata = '0;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       addr,
  input logic       wr_en,
  input logic [7:0] rdata,
  input logic       vec_valid,
  input logic [7:0] grant_vec,
  input logic [7:0] mask_q,
  input logic [7:0] casc_q,
  input logic [7:0] isr_q,
  input logic       aeoi_q,
  input logic       isr_armed,
  input logic       init_active,
  input logic [7:0] offset_q
);
  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R11
  AST_GRANT_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != 8'h00) |-> ((grant_vec & (mask_q | casc_q | isr_q)) == 8'h00)); // R9
  AST_VALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != 8'h00) |=> vec_valid); // R10
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec == 8'h00) |=> !vec_valid); // R10
  AST_GRANT_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_vec != 8'h00) && !aeoi_q) |=> ((isr_q & $past(grant_vec)) != 8'h00)); // R10
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr && !isr_armed) |-> (rdata == 8'h00)); // R7
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_q[2:0] == 3'b000)); // R2
  AST_MASK_HELD_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (init_active && wr_en && addr) |=> $stable(mask_q)); // R5
endmodule

bind irq_ctrl_core irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rdata(rdata),
  .vec_valid(vec_valid), .grant_vec(grant_vec), .mask_q(mask_q),
  .casc_q(casc_q), .isr_q(isr_q), .aeoi_q(aeoi_q), .isr_armed(isr_armed),
  .init_active(init_active), .offset_q(offset_q)
);

// File: tb/irq_ctrl_core_test.sv
`timescale 1ns/1ps
module irq_ctrl_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00, irq_req = 8'h00;
  logic [7:0] rdata, vec_out;
  logic       vec_valid;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctrl_core uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_req(irq_req),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic strobe(logic [7:0] lines, output logic v, output logic [7:0] vec);
    @(negedge clk); irq_req = lines;
    @(negedge clk); irq_req = 8'h00;
    v = vec_valid; vec = vec_out;
  endtask

  function automatic logic [7:0] expect_vec(logic [7:0] base, int n);
    return (base / 8) * 8 + 8'(n);
  endfunction

  task automatic read_isr(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 vec_valid after reset", {7'd0, vec_valid}, 8'h00);
    rd(1'b1, d); chk("R1 mask after reset", d, 8'h00);
    rd(1'b0, d); chk("R7 command read idle", d, 8'h00);
    read_isr(d); chk("R1 isr after reset", d, 8'h00);
    wr(1'b1, 8'h5C); rd(1'b1, d); chk("R1 setup inactive, data loads mask", d, 8'h5C);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_cascade_setup;
    logic [7:0] d, vec; logic v;
    wr(1'b1, 8'h21);
    wr(1'b0, 8'h11); wr(1'b1, 8'h2D); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R5 mask unchanged by setup bytes", d, 8'h21);
    wr(1'b1, 8'h00); rd(1'b1, d); chk("R3 setup ended after mode byte", d, 8'h00);
    strobe(8'h08, v, vec);
    chk("R10 grant valid line3", {7'd0, v}, 8'h01);
    chk("R2 R10 vector base+3", vec, expect_vec(8'h2D, 3));
    @(negedge clk); chk("R10 valid lasts one cycle", {7'd0, vec_valid}, 8'h00);
    read_isr(d); chk("R6 armed read returns isr", d, 8'h08);
    rd(1'b0, d); chk("R7 flag cleared after read", d, 8'h00);
    strobe(8'h04, v, vec); chk("R9 cascade line dropped", {7'd0, v}, 8'h00);
    strobe(8'h08, v, vec); chk("R9 busy line dropped", {7'd0, v}, 8'h00);
    wr(1'b0, 8'h43); read_isr(d); chk("R8 no-EOI write ignored", d, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R6 other OCW3 value not arming", d, 8'h00);
    wr(1'b0, 8'h63); read_isr(d); chk("R8 specific end clears line3", d, 8'h00);
    strobe(8'h08, v, vec); chk("R10 regrant after end", {7'd0, v}, 8'h01);
    strobe(8'h20, v, vec); read_isr(d); chk("R10 two lines in service", d, 8'h28);
    wr(1'b0, 8'h65); read_isr(d); chk("R8 specific end clears line5 only", d, 8'h08);
    wr(1'b0, 8'h20); read_isr(d); chk("R8 nonspecific end clears all", d, 8'h00);
    wr(1'b1, 8'h10); strobe(8'h10, v, vec); chk("R9 masked line dropped", {7'd0, v}, 8'h00);
    rd(1'b1, d); chk("R5 mask readback", d, 8'h10);
    wr(1'b1, 8'h00);
    strobe(8'hA1, v, vec);
    chk("R11 lowest line wins", vec, expect_vec(8'h28, 0));
    read_isr(d); chk("R11 others dropped", d, 8'h01);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_single_short;
    logic [7:0] d, vec; logic v;
    wr(1'b1, 8'h33);
    wr(1'b0, 8'h12); wr(1'b1, 8'h77);
    rd(1'b1, d); chk("R5 mask kept through base byte", d, 8'h33);
    wr(1'b1, 8'h5A); rd(1'b1, d); chk("R3 single no-mode ends after base", d, 8'h5A);
    wr(1'b1, 8'h00);
    strobe(8'h02, v, vec); chk("R2 base masked to F8", vec, expect_vec(8'h77, 1));
    wr(1'b0, 8'h20);
  endtask

  task automatic t_auto_end;
    logic [7:0] d, vec; logic v;
    wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h03);
    wr(1'b1, 8'h00); rd(1'b1, d); chk("R3 single with mode byte skips cascade", d, 8'h00);
    strobe(8'h40, v, vec); chk("R4 vector line6", vec, expect_vec(8'h40, 6));
    read_isr(d); chk("R4 auto end leaves isr clear", d, 8'h00);
    strobe(8'h40, v, vec); chk("R4 line regranted", {7'd0, v}, 8'h01);
  endtask

  task automatic t_cascade_short;
    logic [7:0] d, vec; logic v;
    wr(1'b0, 8'h10); wr(1'b1, 8'h88); wr(1'b1, 8'h80);
    wr(1'b1, 8'h02); rd(1'b1, d); chk("R3 cascade no-mode ends after cascade", d, 8'h02);
    strobe(8'h80, v, vec); chk("R9 new cascade line dropped", {7'd0, v}, 8'h00);
    strobe(8'h02, v, vec); chk("R9 masked line1 dropped", {7'd0, v}, 8'h00);
    strobe(8'h01, v, vec); chk("R10 vector base 88", vec, expect_vec(8'h88, 0));
    read_isr(d); chk("R4 auto end held across setup", d, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cascade_setup();
    t_single_short();
    t_auto_end();
    t_cascade_short();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule